// File: doc/BRIEF.md
# Banked RAM Address Decoder

This block sits between an 8-bit 6502-style processor and its memories. It decodes each bus cycle into exactly one of four selects: RAM, ROM, general I/O, or a slow peripheral. It also produces read and write strobes that are gated by PHI2. It extends the RAM address with a small bank register so that a 128 KB RAM can be reached through a 64 KB CPU space.

The low RAM area always reaches bank 0. The window above it is mapped onto whichever bank the register holds. The register sits at an I/O address and is loaded by an ordinary CPU store.

The CPU address is captured while PHI2 is low and frozen while PHI2 is high. Decode and banking therefore cannot change during the data phase. Accesses to the slow peripheral hold RDY low for a set number of PHI2 cycles. At all other times the RDY pin is left floating, so that the processor's own bidirectional RDY is never opposed.

Top module: `bankmap_decode`

## Requirements
- R1: After reset the bank register holds 0 (a window access drives `ram_a_hi` = 0) and RDY is not driven low.
- R2: A write cycle (PHI2 high, RWB = 0) at I/O address $8000 loads `cpu_data_lo` into the bank register. Read cycles at $8000 and write cycles at any other address leave it unchanged.
- R3: For CPU addresses $2000–$7FFF, `ram_a_hi` equals the bank register, so each of banks 0–3 keeps separate data at the same CPU address.
- R4: For CPU addresses $0000–$1FFF, `ram_a_hi` is 0 whatever the bank register holds.
- R5: Exactly one active-low select is asserted in every cycle. `ram_cs_n` covers $0000–$7FFF, `slow_cs_n` covers $8010–$801F, `io_cs_n` covers the rest of $8000–$80FF, and `rom_cs_n` covers $8100–$FFFF.
- R6: `wr_n` is low only while PHI2 is high and RWB is 0.
- R7: `rd_n`, which drives the RAM and ROM output enables, is low only while PHI2 is high and RWB is 1. It is never low during a write cycle, including a write cycle to ROM.
- R8: While PHI2 is high, the selects, the bank target and `ram_a_hi` follow the address captured at the last clock edge that saw PHI2 low. A change on `cpu_addr` during the high phase has no effect.
- R9: When the slow peripheral is addressed, `rdy` is driven low from the start of the access. It is driven low until WAIT_CYCLES PHI2 cycles with that address have ended, and is then released to high impedance. It is never driven high (default WAIT_CYCLES = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, faster than PHI2 |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data_lo | input | 2 | Low CPU data lines, the bank value |
| cpu_rwb | input | 1 | Raw CPU read/write line, 1 = read |
| phi2 | input | 1 | CPU phase-2 clock level |
| ram_a_hi | output | 2 | Extra RAM address lines A16:A15 |
| ram_cs_n | output | 1 | RAM chip select |
| rom_cs_n | output | 1 | ROM chip select |
| io_cs_n | output | 1 | General I/O select |
| slow_cs_n | output | 1 | Slow peripheral select |
| rd_n | output | 1 | Read strobe for memory output enables |
| wr_n | output | 1 | PHI2-qualified write strobe |
| rdy | output | 1 | Wait request: low or high impedance |

## Verification
A bank-register store and the address freeze fall in the same cycle when the CPU bus changes during the data phase of that store. The bench provokes this by moving `cpu_addr` from $8000 into the banked window halfway through the PHI2-high phase.

It judges the result two ways. First, the selects must still show I/O after the disturbance. Second, a later window read must report the newly written bank. A second overlap, between a wait request and a PHI2 falling edge that coincides with a new address, is exercised by placing a slow access right after a ROM cycle.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

   typedef enum logic [1:0] {
      SEL_RAM  = 2'd0,
      SEL_ROM  = 2'd1,
      SEL_IO   = 2'd2,
      SEL_SLOW = 2'd3
   } region_e;

   localparam int unsigned REGION_N = 4;

   function automatic logic in_span(input logic [15:0] a,
                                    input logic [15:0] lo,
                                    input logic [15:0] hi);
      return (a >= lo) && (a <= hi);
   endfunction

endpackage

// File: rtl/bankmap_addr_hold.sv
module bankmap_addr_hold #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_held,
   output logic [ADDR_W-1:0] addr_eff
);

   // follow the bus while PHI2 is low, freeze while it is high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_held <= '0;
      else if (!phi2)
         addr_held <= addr_in;
   end

   assign addr_eff = phi2 ? addr_held : addr_in;

endmodule

// File: rtl/bankmap_region.sv
module bankmap_region
   import bankmap_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] WIN_END   = 16'h8000,
   parameter logic [ADDR_W-1:0] IO_BASE   = 16'h8000,
   parameter logic [ADDR_W-1:0] IO_LAST   = 16'h80FF,
   parameter logic [ADDR_W-1:0] SLOW_BASE = 16'h8010,
   parameter logic [ADDR_W-1:0] SLOW_LAST = 16'h801F
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);

   // slow range is carved out of the I/O page, so it is tested first
   always_comb begin
      if (addr < WIN_END)
         region = SEL_RAM;
      else if ((addr >= SLOW_BASE) && (addr <= SLOW_LAST))
         region = SEL_SLOW;
      else if ((addr >= IO_BASE) && (addr <= IO_LAST))
         region = SEL_IO;
      else
         region = SEL_ROM;
   end

endmodule

// File: rtl/bankmap_bank_reg.sv
module bankmap_bank_reg #(
   parameter int              ADDR_W        = 16,
   parameter int              BANK_W        = 2,
   parameter logic [ADDR_W-1:0] BANK_REG_ADDR = 16'h8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic              rwb,
   input  logic [ADDR_W-1:0] addr_eff,
   input  logic [BANK_W-1:0] data_lo,
   output logic [BANK_W-1:0] bank
);

   logic load;
   assign load = phi2 && !rwb && (addr_eff == BANK_REG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bank <= '0;
      else if (load)
         bank <= data_lo;
   end

endmodule

// File: rtl/bankmap_wait.sv
module bankmap_wait #(
   parameter int              ADDR_W      = 16,
   parameter int              WAIT_CYCLES = 1,
   parameter logic [ADDR_W-1:0] SLOW_BASE   = 16'h8010,
   parameter logic [ADDR_W-1:0] SLOW_LAST   = 16'h801F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic [ADDR_W-1:0] addr_held,
   input  logic              slow_now,
   output logic              hold
);

   localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
   localparam logic [CNT_W-1:0] WAIT_LIM = CNT_W'(WAIT_CYCLES);

   logic             phi2_q;
   logic             phi2_fall;
   logic             slow_held;
   logic [CNT_W-1:0] served;

   assign phi2_fall = phi2_q && !phi2;
   // the phase that just ended used the frozen address
   assign slow_held = (addr_held >= SLOW_BASE) && (addr_held <= SLOW_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phi2_q <= 1'b0;
      else
         phi2_q <= phi2;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         served <= '0;
      else if (!slow_now)
         served <= '0;
      else if (phi2_fall && slow_held && (served < WAIT_LIM))
         served <= served + 1'b1;
   end

   assign hold = slow_now && (served < WAIT_LIM);

endmodule

// File: rtl/bankmap_decode.sv
module bankmap_decode
   import bankmap_pkg::*;
#(
   parameter int              ADDR_W        = 16,
   parameter int              BANK_W        = 2,
   parameter logic [ADDR_W-1:0] FIX_END       = 16'h2000,
   parameter logic [ADDR_W-1:0] WIN_END       = 16'h8000,
   parameter logic [ADDR_W-1:0] IO_BASE       = 16'h8000,
   parameter logic [ADDR_W-1:0] IO_LAST       = 16'h80FF,
   parameter logic [ADDR_W-1:0] SLOW_BASE     = 16'h8010,
   parameter logic [ADDR_W-1:0] SLOW_LAST     = 16'h801F,
   parameter logic [ADDR_W-1:0] BANK_REG_ADDR = 16'h8000,
   parameter int              WAIT_CYCLES   = 1,
   parameter bit              RDY_TRISTATE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [BANK_W-1:0] cpu_data_lo,
   input  logic              cpu_rwb,
   input  logic              phi2,
   output logic [BANK_W-1:0] ram_a_hi,
   output logic              ram_cs_n,
   output logic              rom_cs_n,
   output logic              io_cs_n,
   output logic              slow_cs_n,
   output logic              rd_n,
   output logic              wr_n,
   output wire               rdy
);

   // elaboration-time parameter checks
   if (BANK_W < 1 || BANK_W > 8) begin : g_bad_bank_w
      $error("bankmap_decode: BANK_W out of range");
   end
   if (WAIT_CYCLES < 1) begin : g_bad_wait
      $error("bankmap_decode: WAIT_CYCLES must be at least 1");
   end
   if (FIX_END > WIN_END) begin : g_bad_window
      $error("bankmap_decode: fixed area overlaps past the window");
   end
   if (SLOW_BASE < IO_BASE || SLOW_LAST > IO_LAST || SLOW_BASE > SLOW_LAST) begin : g_bad_slow
      $error("bankmap_decode: slow range must sit inside the I/O page");
   end
   if (BANK_REG_ADDR < IO_BASE || BANK_REG_ADDR > IO_LAST ||
       (BANK_REG_ADDR >= SLOW_BASE && BANK_REG_ADDR <= SLOW_LAST)) begin : g_bad_breg
      $error("bankmap_decode: bank register must be a fast I/O address");
   end

   logic [ADDR_W-1:0]   addr_held;
   logic [ADDR_W-1:0]   addr_eff;
   logic [BANK_W-1:0]   bank_q;
   logic                wait_hold;
   region_e             region;
   logic [REGION_N-1:0] sel_n;

   bankmap_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .phi2      (phi2),
      .addr_in   (cpu_addr),
      .addr_held (addr_held),
      .addr_eff  (addr_eff)
   );

   bankmap_region #(
      .ADDR_W    (ADDR_W),
      .WIN_END   (WIN_END),
      .IO_BASE   (IO_BASE),
      .IO_LAST   (IO_LAST),
      .SLOW_BASE (SLOW_BASE),
      .SLOW_LAST (SLOW_LAST)
   ) u_region (
      .addr   (addr_eff),
      .region (region)
   );

   bankmap_bank_reg #(
      .ADDR_W        (ADDR_W),
      .BANK_W        (BANK_W),
      .BANK_REG_ADDR (BANK_REG_ADDR)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .phi2     (phi2),
      .rwb      (cpu_rwb),
      .addr_eff (addr_eff),
      .data_lo  (cpu_data_lo),
      .bank     (bank_q)
   );

   bankmap_wait #(
      .ADDR_W      (ADDR_W),
      .WAIT_CYCLES (WAIT_CYCLES),
      .SLOW_BASE   (SLOW_BASE),
      .SLOW_LAST   (SLOW_LAST)
   ) u_wait (
      .clk       (clk),
      .rst_n     (rst_n),
      .phi2      (phi2),
      .addr_held (addr_held),
      .slow_now  (region == SEL_SLOW),
      .hold      (wait_hold)
   );

   // one active-low select per region code
   for (genvar gi = 0; gi < REGION_N; gi++) begin : g_sel
      assign sel_n[gi] = (region != region_e'(gi));
   end

   assign ram_cs_n  = sel_n[SEL_RAM];
   assign rom_cs_n  = sel_n[SEL_ROM];
   assign io_cs_n   = sel_n[SEL_IO];
   assign slow_cs_n = sel_n[SEL_SLOW];

   // upper RAM lines: bank only inside the switchable window
   assign ram_a_hi = ((region == SEL_RAM) && (addr_eff >= FIX_END)) ? bank_q : '0;

   // strobes are PHI2-qualified; raw RWB never reaches memory directly
   assign rd_n = ~(phi2 &  cpu_rwb);
   assign wr_n = ~(phi2 & ~cpu_rwb);

   if (RDY_TRISTATE) begin : g_rdy_float
      assign rdy = wait_hold ? 1'b0 : 1'bz;
   end else begin : g_rdy_push
      assign rdy = ~wait_hold;
   end

endmodule

// File: rtl/bankmap_chk.sv
module bankmap_chk #(
   parameter int              ADDR_W        = 16,
   parameter int              BANK_W        = 2,
   parameter logic [ADDR_W-1:0] FIX_END       = 16'h2000,
   parameter logic [ADDR_W-1:0] BANK_REG_ADDR = 16'h8000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              phi2,
   input logic              cpu_rwb,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [BANK_W-1:0] ram_a_hi,
   input logic              ram_cs_n,
   input logic              rom_cs_n,
   input logic              io_cs_n,
   input logic              slow_cs_n,
   input logic              rd_n,
   input logic              wr_n,
   input logic [BANK_W-1:0] bank_q,
   input logic [ADDR_W-1:0] addr_held,
   input logic              wait_hold
);

   // R5
   one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~ram_cs_n, ~rom_cs_n, ~io_cs_n, ~slow_cs_n}) == 1);

   // R7
   no_rd_on_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rwb |-> rd_n);

   // R6
   wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !phi2 |-> wr_n);

   // R4
   fixed_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!phi2 && (cpu_addr < FIX_END)) |-> (ram_a_hi == '0));

   // R8
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phi2 && $past(phi2)) |-> $stable(addr_held));

   // R2
   bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(phi2 && !cpu_rwb && (addr_held == BANK_REG_ADDR)) |=> $stable(bank_q));

   // R9
   rdy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slow_cs_n |-> !wait_hold);

endmodule

bind bankmap_decode bankmap_chk #(
   .ADDR_W        (ADDR_W),
   .BANK_W        (BANK_W),
   .FIX_END       (FIX_END),
   .BANK_REG_ADDR (BANK_REG_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .phi2      (phi2),
   .cpu_rwb   (cpu_rwb),
   .cpu_addr  (cpu_addr),
   .ram_a_hi  (ram_a_hi),
   .ram_cs_n  (ram_cs_n),
   .rom_cs_n  (rom_cs_n),
   .io_cs_n   (io_cs_n),
   .slow_cs_n (slow_cs_n),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .bank_q    (bank_q),
   .addr_held (addr_held),
   .wait_hold (wait_hold)
);

// File: tb/tb_bankmap_decode.sv
module tb_bankmap_decode;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [1:0]  cpu_data_lo = 2'b00;
   logic [7:0]  cpu_data = 8'h00;
   logic        cpu_rwb = 1'b1;
   logic        phi2 = 1'b0;
   logic [1:0]  ram_a_hi;
   logic        ram_cs_n, rom_cs_n, io_cs_n, slow_cs_n, rd_n, wr_n;
   wire         rdy_w;

   pullup (rdy_w);

   always #4 clk = ~clk;

   bankmap_decode dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_addr    (cpu_addr),
      .cpu_data_lo (cpu_data_lo),
      .cpu_rwb     (cpu_rwb),
      .phi2        (phi2),
      .ram_a_hi    (ram_a_hi),
      .ram_cs_n    (ram_cs_n),
      .rom_cs_n    (rom_cs_n),
      .io_cs_n     (io_cs_n),
      .slow_cs_n   (slow_cs_n),
      .rd_n        (rd_n),
      .wr_n        (wr_n),
      .rdy         (rdy_w)
   );

   // external RAM model indexed by the physical lines the test touches
   logic [7:0] mem [0:255];
   wire  [7:0] midx = {ram_a_hi, cpu_addr[14:13], cpu_addr[3:0]};
   always @(posedge clk) if (!ram_cs_n && !wr_n) mem[midx] <= cpu_data;

   int n_chk = 0;
   int n_bad = 0;
   logic [1:0] s_ahi;
   logic [3:0] s_cs;      // {slow, io, rom, ram}, active low
   logic       s_rd, s_wr, s_rdy, p_rd, p_wr, p_rdy;
   logic [7:0] s_rdata;

   localparam logic [3:0] CS_RAM  = 4'b1110;
   localparam logic [3:0] CS_ROM  = 4'b1101;
   localparam logic [3:0] CS_IO   = 4'b1011;
   localparam logic [3:0] CS_SLOW = 4'b0111;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one CPU cycle: 4 clocks PHI2 low, 4 clocks PHI2 high
   task automatic bus(input logic [15:0] a, input logic rw,
                      input logic [7:0] d, input bit disturb = 1'b0);
      @(negedge clk);
      phi2 = 1'b0; cpu_addr = a; cpu_rwb = rw; cpu_data = d; cpu_data_lo = d[1:0];
      @(negedge clk);
      p_rd = rd_n; p_wr = wr_n; p_rdy = rdy_w;
      repeat (3) @(negedge clk);
      phi2 = 1'b1;
      @(negedge clk);
      if (disturb) cpu_addr = 16'h2003;
      @(negedge clk);
      s_ahi = ram_a_hi;
      s_cs  = {slow_cs_n, io_cs_n, rom_cs_n, ram_cs_n};
      s_rd  = rd_n; s_wr = wr_n; s_rdy = rdy_w;
      s_rdata = (!ram_cs_n && !rd_n) ? mem[midx] : 8'hFF;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset;
      bus(16'h2003, 1'b1, 8'h00);
      chk("R1 bank after reset", s_ahi, 0);
      chk("R1 rdy after reset", s_rdy, 1);
   endtask

   task automatic t_banks;
      for (int b = 0; b < 4; b++) begin
         bus(16'h8000, 1'b0, 8'(b));
         bus(16'h2003, 1'b0, 8'hA0 + 8'(b));
         chk("R3 window a_hi on write", s_ahi, b);
         bus(16'h7FF3, 1'b0, 8'hC0 + 8'(b));
      end
      for (int b = 3; b >= 0; b--) begin
         bus(16'h8000, 1'b0, 8'(b));
         bus(16'h2003, 1'b1, 8'h00);
         chk("R2 bank loaded", s_ahi, b);
         chk("R3 readback low window", s_rdata, 8'hA0 + b);
         bus(16'h7FF3, 1'b1, 8'h00);
         chk("R3 readback top window", s_rdata, 8'hC0 + b);
      end
   endtask

   task automatic t_fixed;
      bus(16'h8000, 1'b0, 8'h03);
      bus(16'h0005, 1'b0, 8'h55);
      chk("R4 fixed a_hi bank3", s_ahi, 0);
      bus(16'h8000, 1'b0, 8'h01);
      bus(16'h0005, 1'b1, 8'h00);
      chk("R4 fixed readback bank1", s_rdata, 8'h55);
      bus(16'h1FFF, 1'b1, 8'h00);
      chk("R4 fixed top edge", s_ahi, 0);
      bus(16'h2000, 1'b1, 8'h00);
      chk("R3 window bottom edge", s_ahi, 1);
   endtask

   task automatic t_ignored;
      bus(16'h8000, 1'b0, 8'h02);
      bus(16'h8000, 1'b1, 8'h03);
      bus(16'h8001, 1'b0, 8'h03);
      bus(16'h2000, 1'b1, 8'h00);
      chk("R2 read/other write ignored", s_ahi, 2);
   endtask

   task automatic t_selects;
      logic [15:0] al [10] = '{16'h0000, 16'h7FFF, 16'h8000, 16'h800F, 16'h8010,
                               16'h801F, 16'h8020, 16'h80FF, 16'h8100, 16'hFFFF};
      logic [3:0]  el [10] = '{CS_RAM, CS_RAM, CS_IO, CS_IO, CS_SLOW,
                               CS_SLOW, CS_IO, CS_IO, CS_ROM, CS_ROM};
      for (int i = 0; i < 10; i++) begin
         bus(al[i], 1'b1, 8'h00);
         chk("R5 select map", s_cs, el[i]);
      end
   endtask

   task automatic t_strobes;
      bus(16'h9000, 1'b0, 8'h00);
      chk("R7 no rd on rom write", s_rd, 1);
      chk("R6 wr in high phase", s_wr, 0);
      chk("R6 no wr in low phase", p_wr, 1);
      chk("R7 no rd in low phase", p_rd, 1);
      chk("R5 rom select", s_cs, CS_ROM);
      bus(16'h9000, 1'b1, 8'h00);
      chk("R7 rd on read", s_rd, 0);
      chk("R6 no wr on read", s_wr, 1);
   endtask

   task automatic t_hold;
      bus(16'h8000, 1'b0, 8'h01, 1'b1);
      chk("R8 select frozen", s_cs, CS_IO);
      bus(16'h2000, 1'b1, 8'h00);
      chk("R8 bank write survives disturb", s_ahi, 1);
   endtask

   task automatic t_wait;
      bus(16'h9000, 1'b1, 8'h00);
      bus(16'h8012, 1'b1, 8'h00);
      chk("R9 rdy low from start", p_rdy, 0);
      chk("R9 rdy low in data phase", s_rdy, 0);
      chk("R5 slow select", s_cs, CS_SLOW);
      bus(16'h8012, 1'b1, 8'h00);
      chk("R9 rdy released after wait", s_rdy, 1);
      chk("R9 rdy released low phase", p_rdy, 1);
      bus(16'h9000, 1'b1, 8'h00);
      chk("R9 rdy floats on rom", s_rdy, 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_banks();
      t_fixed();
      t_ignored();
      t_selects();
      t_strobes();
      t_hold();
      t_wait();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule